// File: doc/BRIEF.md
# Serial Control Receiver for a Stereo Volume and Tone Processor

This block receives the two-wire serial control traffic of a stereo volume and tone processor and keeps the decoded settings in registers that steer the analog section. A fast system clock samples the bus clock and data lines through synchronizers. The block finds the start and stop conditions, accepts transfers sent to its fixed 7-bit address with the write direction, and acknowledges every byte of such a transfer by pulling the data line low.

There is no subaddress pointer. Each data byte carries a leading bit pattern that names its target register. One transfer can therefore update any mix of settings in any order. The outputs hold the master volume, four speaker attenuations with a mute flag each, the input select, the input gain, the loudness enable and the bass and treble codes. The block only receives. It does not stretch the clock and it never answers a read.

Top module: `audio_ctl_rx`

## Requirements
- R1: After reset: volume code 6'b111111; every attenuator code 5'b11111 with its mute flag set; input select 2'b00 (input 1); gain code 2'b11 (0 dB); loudness disabled; bass and treble code 4'b0111 (flat).
- R2: A transfer begins only when data falls while the bus clock is high. Clock pulses seen without a preceding start get no acknowledge and change no setting.
- R3: The block acknowledges an address byte equal to 7'b1000100 followed by a 0 direction bit. The pull-down begins after the bus clock falls at the end of bit 8 and is removed after the bus clock falls at the end of the ninth clock.
- R4: When the address differs or the direction bit is 1, the block releases the data line and ignores every byte until the next start.
- R5: A data byte with bits 7:6 = 00 loads bits 5:0 into the volume code (bits 5:3 in 10 dB steps, bits 2:0 in 1.25 dB steps).
- R6: A data byte with bit 7 = 1 loads bits 4:0 into the attenuator chosen by bits 6:5 (00 left front, 01 right front, 10 left rear, 11 right rear). That speaker's mute flag is set exactly when bits 4:0 are 11111.
- R7: A data byte with bits 7:5 = 010 loads gain from bits 4:3 (00 +11.25 dB through 11 0 dB) and input select from bits 1:0. Loudness is enabled when bit 2 is 0.
- R8: In such a byte, the reserved input code 11 leaves the input select unchanged while gain and loudness still update.
- R9: A data byte with bits 7:4 = 0110 loads bits 3:0 into the bass code, and bits 7:4 = 0111 loads bits 3:0 into the treble code.
- R10: A start or stop that arrives before all 8 bits of a byte have been clocked discards that byte. No register changes.
- R11: Any number of data bytes may follow one address byte up to the stop. Each byte is acknowledged and applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | 1 pulls the data line low (acknowledge) |
| vol_o | output | 6 | Master volume code |
| att_lf_o | output | 5 | Left front attenuator code |
| att_rf_o | output | 5 | Right front attenuator code |
| att_lr_o | output | 5 | Left rear attenuator code |
| att_rr_o | output | 5 | Right rear attenuator code |
| mute_o | output | 4 | Mute flags: bit0 LF, bit1 RF, bit2 LR, bit3 RR |
| in_sel_o | output | 2 | Input select, 00/01/10 = input 1/2/3 |
| gain_o | output | 2 | Input gain code |
| loud_en_o | output | 1 | 1 when loudness is on |
| bass_o | output | 4 | Bass code, bit 3 is the sign |
| treble_o | output | 4 | Treble code, bit 3 is the sign |

## Verification
The hardest case to reach from the pins is a byte cut short by a bus condition. The master has already clocked part of a byte into the shift register, and a repeated start or a stop arrives before bit 8. The stimulus drives a valid address, clocks only the first few bits of a volume byte that would change the setting, and then issues a start or a stop. Only after the stop does it compare the settings with the model. An ignored transfer is reached the same way: a wrong address or a read bit, followed by a byte that would otherwise be accepted.

// File: rtl/audio_ctl_pkg.sv
package audio_ctl_pkg;
  localparam int VOL_W  = 6;
  localparam int ATT_W  = 5;
  localparam int TONE_W = 4;
  localparam int N_SPK  = 4;

  localparam logic [VOL_W-1:0]  VOL_RST  = '1;
  localparam logic [ATT_W-1:0]  ATT_RST  = '1;
  localparam logic [TONE_W-1:0] TONE_RST = 4'b0111;
  localparam logic [1:0]        SEL_RST  = 2'b00;
  localparam logic [1:0]        GAIN_RST = 2'b11;
  localparam logic [1:0]        SEL_RSVD = 2'b11;

  typedef enum logic [2:0] {
    RX_OFF,      // not addressed, waiting for a start
    RX_BITS,     // shifting in data bits
    RX_ACK_SET,  // 8 bits in, waiting for clock fall to drive ack
    RX_ACK_HOLD, // ack driven, waiting for ninth clock rise
    RX_ACK_END   // ninth clock high, waiting for its fall
  } rx_state_t;
endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_up,
  output logic scl_dn,
  output logic cond_start,
  output logic cond_stop,
  output logic sda_s
);
  localparam int LINES = 2;
  logic [LINES-1:0][STAGES-1:0] chain;
  logic [LINES-1:0] line_prev;
  logic [LINES-1:0] line_now;
  logic [LINES-1:0] line_raw;

  assign line_raw = {sda_i, scl_i};

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain[i]     <= '1;
        line_prev[i] <= 1'b1;
      end else begin
        chain[i]     <= {chain[i][STAGES-2:0], line_raw[i]};
        line_prev[i] <= chain[i][STAGES-1];
      end
    end
    assign line_now[i] = chain[i][STAGES-1];
  end

  assign sda_s      = line_now[1];
  assign scl_up     = line_now[0] & ~line_prev[0];
  assign scl_dn     = ~line_now[0] & line_prev[0];
  assign cond_start = line_now[0] & line_prev[0] & ~line_now[1] & line_prev[1];
  assign cond_stop  = line_now[0] & line_prev[0] & line_now[1] & ~line_prev[1];
endmodule

// File: rtl/byte_receiver.sv
module byte_receiver
  import audio_ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_up,
  input  logic       scl_dn,
  input  logic       cond_start,
  input  logic       cond_stop,
  input  logic       sda_s,
  output logic       pull,
  output logic       byte_stb,
  output logic [7:0] byte_q
);
  localparam int CNT_W = 3;
  rx_state_t st;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0] shreg;
  logic [7:0] shreg_nx;
  logic addr_phase;

  assign shreg_nx = {shreg[6:0], sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= RX_OFF;
      bit_cnt    <= '0;
      shreg      <= '0;
      addr_phase <= 1'b0;
      pull       <= 1'b0;
      byte_stb   <= 1'b0;
      byte_q     <= '0;
    end else begin
      byte_stb <= 1'b0;
      if (cond_start) begin
        st         <= RX_BITS;
        bit_cnt    <= '0;
        addr_phase <= 1'b1;
        pull       <= 1'b0;
      end else if (cond_stop) begin
        st   <= RX_OFF;
        pull <= 1'b0;
      end else begin
        unique case (st)
          RX_BITS: if (scl_up) begin
            shreg   <= shreg_nx;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CNT_W'(7)) begin
              st <= RX_ACK_SET;
              if (!addr_phase) begin
                byte_stb <= 1'b1;
                byte_q   <= shreg_nx;
              end
            end
          end
          RX_ACK_SET: if (scl_dn) begin
            if (addr_phase && (shreg[7:1] != DEV_ADDR || shreg[0])) begin
              st <= RX_OFF;
            end else begin
              st   <= RX_ACK_HOLD;
              pull <= 1'b1;
            end
          end
          RX_ACK_HOLD: if (scl_up) st <= RX_ACK_END;
          RX_ACK_END: if (scl_dn) begin
            st         <= RX_BITS;
            pull       <= 1'b0;
            addr_phase <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/setting_regs.sv
module setting_regs
  import audio_ctl_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         byte_stb,
  input  logic [7:0]                   byte_q,
  output logic [VOL_W-1:0]             vol,
  output logic [N_SPK-1:0][ATT_W-1:0]  att,
  output logic [N_SPK-1:0]             mute,
  output logic [1:0]                   in_sel,
  output logic [1:0]                   gain,
  output logic                         loud_en,
  output logic [TONE_W-1:0]            bass,
  output logic [TONE_W-1:0]            treble
);
  logic hit_vol, hit_att, hit_sw, hit_bass, hit_treb;

  assign hit_vol  = byte_stb && byte_q[7:6] == 2'b00;
  assign hit_att  = byte_stb && byte_q[7];
  assign hit_sw   = byte_stb && byte_q[7:5] == 3'b010;
  assign hit_bass = byte_stb && byte_q[7:4] == 4'b0110;
  assign hit_treb = byte_stb && byte_q[7:4] == 4'b0111;

  for (genvar g = 0; g < N_SPK; g++) begin : g_spk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        att[g]  <= ATT_RST;
        mute[g] <= 1'b1;
      end else if (hit_att && byte_q[6:5] == 2'(g)) begin
        att[g]  <= byte_q[ATT_W-1:0];
        mute[g] <= &byte_q[ATT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vol     <= VOL_RST;
      in_sel  <= SEL_RST;
      gain    <= GAIN_RST;
      loud_en <= 1'b0;
      bass    <= TONE_RST;
      treble  <= TONE_RST;
    end else begin
      if (hit_vol) vol <= byte_q[VOL_W-1:0];
      if (hit_sw) begin
        gain    <= byte_q[4:3];
        loud_en <= ~byte_q[2];
        if (byte_q[1:0] != SEL_RSVD) in_sel <= byte_q[1:0];
      end
      if (hit_bass) bass   <= byte_q[TONE_W-1:0];
      if (hit_treb) treble <= byte_q[TONE_W-1:0];
    end
  end
endmodule

// File: rtl/audio_ctl_rx.sv
module audio_ctl_rx
  import audio_ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1000100,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic [VOL_W-1:0]  vol_o,
  output logic [ATT_W-1:0]  att_lf_o,
  output logic [ATT_W-1:0]  att_rf_o,
  output logic [ATT_W-1:0]  att_lr_o,
  output logic [ATT_W-1:0]  att_rr_o,
  output logic [N_SPK-1:0]  mute_o,
  output logic [1:0]        in_sel_o,
  output logic [1:0]        gain_o,
  output logic              loud_en_o,
  output logic [TONE_W-1:0] bass_o,
  output logic [TONE_W-1:0] treble_o
);
  logic scl_up, scl_dn, cond_start, cond_stop, sda_s;
  logic byte_stb;
  logic [7:0] byte_q;
  logic [N_SPK-1:0][ATT_W-1:0] att;

  bus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_up(scl_up), .scl_dn(scl_dn), .cond_start(cond_start),
    .cond_stop(cond_stop), .sda_s(sda_s)
  );

  byte_receiver #(.DEV_ADDR(DEV_ADDR)) u_rx (
    .clk(clk), .rst_n(rst_n), .scl_up(scl_up), .scl_dn(scl_dn),
    .cond_start(cond_start), .cond_stop(cond_stop), .sda_s(sda_s),
    .pull(sda_pull_o), .byte_stb(byte_stb), .byte_q(byte_q)
  );

  setting_regs u_regs (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_q(byte_q),
    .vol(vol_o), .att(att), .mute(mute_o), .in_sel(in_sel_o),
    .gain(gain_o), .loud_en(loud_en_o), .bass(bass_o), .treble(treble_o)
  );

  assign att_lf_o = att[0];
  assign att_rf_o = att[1];
  assign att_lr_o = att[2];
  assign att_rr_o = att[3];
endmodule

// File: rtl/audio_ctl_rx_chk.sv
module audio_ctl_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_pull_o,
  input logic [5:0] vol_o,
  input logic [4:0] att_lf_o,
  input logic [4:0] att_rr_o,
  input logic [3:0] mute_o,
  input logic [1:0] in_sel_o
);
  // R3
  ack_on_low_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_i);

  // R6
  mute_lf_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mute_o[0] == (&att_lf_o));

  // R6
  mute_rr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mute_o[3] == (&att_rr_o));

  // R8
  no_reserved_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_sel_o != 2'b11);

  // R10
  vol_update_clock_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vol_o) |-> scl_i);
endmodule

bind audio_ctl_rx audio_ctl_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .vol_o(vol_o), .att_lf_o(att_lf_o), .att_rr_o(att_rr_o),
  .mute_o(mute_o), .in_sel_o(in_sel_o)
);

// File: tb/sim_audio_ctl_rx.sv
module sim_audio_ctl_rx;
  localparam int Q = 10;

  typedef struct packed {
    logic [5:0]      vol;
    logic [3:0][4:0] att;
    logic [3:0]      mute;
    logic [1:0]      sel;
    logic [1:0]      gain;
    logic            loud;
    logic [3:0]      bass;
    logic [3:0]      treb;
  } snap_t;

  logic clk = 0;
  logic rst_n = 0;
  logic scl = 1;
  logic m_sda = 1;
  logic sda_pull;
  logic sda_bus;
  logic [5:0] vol;
  logic [4:0] a_lf, a_rf, a_lr, a_rr;
  logic [3:0] mute;
  logic [1:0] sel, gain;
  logic loud;
  logic [3:0] bass, treb;

  int total = 0;
  int bad = 0;
  bit done = 0;
  snap_t exp_s;
  snap_t exp_q[$];
  string tag_q[$];
  event chk_ev;

  always #10 clk = ~clk;
  assign sda_bus = m_sda & ~sda_pull;

  audio_ctl_rx u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .vol_o(vol), .att_lf_o(a_lf), .att_rf_o(a_rf),
    .att_lr_o(a_lr), .att_rr_o(a_rr), .mute_o(mute), .in_sel_o(sel),
    .gain_o(gain), .loud_en_o(loud), .bass_o(bass), .treble_o(treb)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference model written from the requirements
  function automatic void model(input logic [7:0] b);
    if (b[7:6] == 2'b00) exp_s.vol = b[5:0];
    else if (b[7]) begin
      exp_s.att[b[6:5]]  = b[4:0];
      exp_s.mute[b[6:5]] = (b[4:0] == 5'b11111);
    end else if (b[7:5] == 3'b010) begin
      exp_s.gain = b[4:3];
      exp_s.loud = !b[2];
      if (b[1:0] != 2'b11) exp_s.sel = b[1:0];
    end else if (b[7:4] == 4'b0110) exp_s.bass = b[3:0];
    else exp_s.treb = b[3:0];
  endfunction

  task automatic push(input string tag);
    exp_q.push_back(exp_s);
    tag_q.push_back(tag);
    -> chk_ev;
  endtask

  task automatic bus_start();
    m_sda = 1; wq(Q); scl = 1; wq(Q); m_sda = 0; wq(Q); scl = 0; wq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 0; wq(Q); scl = 1; wq(Q); m_sda = 1; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; wq(Q); scl = 1; wq(2 * Q); scl = 0; wq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    send_bits(b, 8);
    m_sda = 1; wq(Q);
    chk(sda_pull == exp_ack, req, 32'(sda_pull), 32'(exp_ack));
    scl = 1; wq(2 * Q);
    chk(sda_pull == exp_ack, req, 32'(sda_pull), 32'(exp_ack));
    scl = 0; wq(Q);
    chk(sda_pull == 1'b0, {req, " release"}, 32'(sda_pull), 0);
  endtask

  task automatic write_data(input logic [7:0] b, input string req);
    send_byte(b, 1'b1, req);
    model(b);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(chk_ev);
      @(negedge clk);
      while (exp_q.size() > 0) begin
        snap_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(vol == e.vol, {t, " vol"}, 32'(vol), 32'(e.vol));
        chk({a_rr, a_lr, a_rf, a_lf} == e.att, {t, " att"}, 32'({a_rr, a_lr, a_rf, a_lf}), 32'(e.att));
        chk(mute == e.mute, {t, " mute"}, 32'(mute), 32'(e.mute));
        chk(sel == e.sel, {t, " sel"}, 32'(sel), 32'(e.sel));
        chk(gain == e.gain, {t, " gain"}, 32'(gain), 32'(e.gain));
        chk(loud == e.loud, {t, " loud"}, 32'(loud), 32'(e.loud));
        chk(bass == e.bass, {t, " bass"}, 32'(bass), 32'(e.bass));
        chk(treb == e.treb, {t, " treble"}, 32'(treb), 32'(e.treb));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    exp_s = '{vol: 6'h3F, att: {4{5'h1F}}, mute: 4'hF, sel: 2'b00,
              gain: 2'b11, loud: 1'b0, bass: 4'h7, treb: 4'h7};
    wq(5); rst_n = 1; wq(5);
    chk(sda_pull == 0, "R1 idle pull", 32'(sda_pull), 0);
    push("R1 reset");
    wq(2);

    // R2: byte without a start is not acknowledged and changes nothing
    send_byte(8'h88, 1'b0, "R2 no start addr");
    send_byte(8'h05, 1'b0, "R2 no start data");
    bus_stop(); push("R2"); wq(2);

    // R3 R5: volume write
    bus_start();
    send_byte(8'h88, 1'b1, "R3 addr ack");
    write_data(8'h24, "R5 vol");
    bus_stop(); push("R5"); wq(2);

    // R6 R11: four attenuators in one transfer, one muted
    bus_start();
    send_byte(8'h88, 1'b1, "R3 addr ack");
    write_data(8'h9F, "R11 lf");
    write_data(8'hB4, "R11 rf");
    write_data(8'hC5, "R11 lr");
    write_data(8'hE0, "R11 rr");
    bus_stop(); push("R6"); wq(2);

    // R7 R9: switch, bass, treble in one transfer
    bus_start();
    send_byte(8'h88, 1'b1, "R3 addr ack");
    write_data(8'h49, "R7 switch");
    write_data(8'h62, "R9 bass");
    write_data(8'h7C, "R9 treble");
    bus_stop(); push("R7 R9"); wq(2);

    // R8: reserved input code keeps select, updates gain and loudness
    bus_start();
    send_byte(8'h88, 1'b1, "R3 addr ack");
    write_data(8'h5F, "R8 reserved");
    bus_stop(); push("R8"); wq(2);

    // R4: wrong address then a byte that would change volume
    bus_start();
    send_byte(8'h8A, 1'b0, "R4 bad addr");
    send_byte(8'h01, 1'b0, "R4 ignored");
    bus_stop(); push("R4 addr"); wq(2);

    // R4: read direction bit
    bus_start();
    send_byte(8'h89, 1'b0, "R4 read bit");
    send_byte(8'h02, 1'b0, "R4 ignored");
    bus_stop(); push("R4 read"); wq(2);

    // R10: partial byte cut by repeated start, then by stop
    bus_start();
    send_byte(8'h88, 1'b1, "R3 addr ack");
    send_bits(8'h03, 5);
    bus_start();
    send_byte(8'h88, 1'b1, "R10 restart addr");
    send_bits(8'h06, 4);
    bus_stop(); push("R10"); wq(2);

    // R5 R11: volume boundary values, last wins
    bus_start();
    send_byte(8'h88, 1'b1, "R3 addr ack");
    write_data(8'h00, "R5 vol min");
    write_data(8'h3F, "R5 vol max");
    write_data(8'h7F, "R9 treble max");
    bus_stop(); push("R5 R11"); wq(20);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule